// File: doc/BRIEF.md
# Bus-Kicked Watchdog Timer

This block is a watchdog that runs from a 32.768 kHz slow clock and raises a reset request when the host stops servicing it. A prescaler divides the slow clock into a 4 Hz tick. A small tick counter advances on every tick. When the counter is already at its top value and one more tick arrives, it overflows and the block raises the reset request. The host services the watchdog by writing to a dedicated bus address. The bus decoder outside this block turns each such write into a strobe, `kick_req`, which may come from another clock domain.

The strobe is synchronized and edge-detected, so a strobe that stays high counts as one service only. A service clears the tick counter. In the default mode the prescaler keeps running, so the timeout lands between three and four tick periods after the last service: 750 ms to 1 s at the default rates. A parameter selects a second mode in which a service also restarts the prescaler, which makes the timeout exactly four tick periods. The reset request is a pulse of fixed length. When the pulse ends, the counter and the prescaler start again from zero. While the enable input is low, the prescaler, the counter and the output are all held at zero.

Top module: `kick_watchdog`

## Requirements
- R1: The prescaler produces one tick every DIV slow-clock cycles (DIV = 8192 by default). Without services, successive reset pulses start exactly TICKS*DIV + PULSE_CYC cycles apart, where TICKS = 2**TICK_W.
- R2: After the enable input rises, with no service, `wd_reset` first goes high exactly TICKS*DIV slow-clock edges after the first edge that samples the enable high.
- R3: A service clears only the tick counter (default mode, CLEAR_MODE = PHASE_FREE). If the clear happens at edge c, counting from the first enabled edge as 1, `wd_reset` rises at edge (floor(c/DIV) + TICKS) * DIV, which is between (TICKS-1)*DIV + 1 and TICKS*DIV edges after the clear.
- R4: `wd_reset` stays high for exactly PULSE_CYC cycles (4 by default). It then falls, and the counter and the prescaler restart from zero.
- R5: While `wd_enable` is 0, `wd_reset` is 0 from the next edge on and the count is held at zero. Enabling again restarts the full timeout of R2.
- R6: While `rst_n` is low at a clock edge, `wd_reset` is driven to 0 and all state is cleared (active-low synchronous reset).
- R7: `kick_req` passes through a two-flop synchronizer followed by a rising-edge detector. A strobe that is first sampled high at edge a+1 clears the counter at edge a+3. A strobe held high counts as a single service.
- R8: With CLEAR_MODE = PHASE_RESTART, a service also restarts the prescaler, so `wd_reset` rises exactly TICKS*DIV edges after the clear edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32.768 kHz slow clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| wd_enable | input | 1 | Arms the watchdog when 1 |
| kick_req | input | 1 | Service strobe from the bus address decoder, asynchronous |
| wd_reset | output | 1 | Reset request pulse |

## Verification
The bench builds the block with DIV = 8, TICK_W = 2 and PULSE_CYC = 4. It uses two instances, one in each clearing mode, so a full timeout takes 32 cycles and a full sweep fits in a short run. With this setting the bench places a service at every clear edge from 3 to 2*DIV+2. That covers every prescaler phase, including clears that land on a tick edge, so the whole 3*DIV+1 to 4*DIV window and the exact restart timing are computed and compared edge by edge. The same small setting also brings within reach pulse length, pulse spacing, a held strobe, and disabling during a pulse.

// File: rtl/wdt_pkg.sv
// Package: shared types for the watchdog.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wdt_pkg;
    // Selects whether a service also restarts the prescaler phase.
    typedef enum logic {
        PHASE_FREE    = 1'b0,
        PHASE_RESTART = 1'b1
    } clear_mode_e;
endpackage

// File: rtl/wdt_kick_sync.sv
// Module: wdt_kick_sync
// Brings the asynchronous service strobe into the slow clock domain through
// SYNC_STAGES flops, then emits a one-cycle pulse on each rising edge.
// Assumes the strobe stays high for at least one slow-clock period.
module wdt_kick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_async,
    output logic kick_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Purpose: resynchronizer chain plus previous-value flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], kick_async};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign kick_pulse = sync_q[SYNC_STAGES-1] & ~last_q;

    // R7: the pulse produced for one strobe lasts a single cycle
    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        kick_pulse |=> !kick_pulse);
endmodule

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Divides the slow clock by DIV and flags the last cycle of each period as a tick.
// Assumes DIV >= 2. A restart forces the phase back to zero.
module wdt_prescaler #(
    parameter int DIV = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Purpose: free-running phase counter that wraps after DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);

    // R1: a tick is always followed by phase zero
    a_r1_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase_q == '0));
    // R1: the phase never leaves its range
    a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
endmodule

// File: rtl/wdt_tick_counter.sv
// Module: wdt_tick_counter
// Counts prescaler ticks. An overflow tick starts a reset pulse of PULSE_CYC
// cycles, and the count clears when the pulse ends. A clear request empties
// the count. Clear requests that arrive during a pulse are ignored.
// Assumes the tick is one cycle wide.
module wdt_tick_counter #(
    parameter int TICK_W    = 2,
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clr,
    input  logic tick,
    output logic pulse_active
);
    localparam int LW = $clog2(PULSE_CYC + 1);
    localparam logic [TICK_W-1:0] CNT_MAX    = '1;
    localparam logic [LW-1:0]     PULSE_LOAD = LW'(PULSE_CYC);

    logic [TICK_W-1:0] cnt_q;
    logic [LW-1:0]     left_q;

    // Purpose: tick count and remaining pulse length, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q  <= '0;
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            if (left_q == LW'(1)) begin
                cnt_q <= '0;
            end
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == CNT_MAX) begin
                left_q <= PULSE_LOAD;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pulse_active = (left_q != '0);

    // R2: a pulse starts only on a tick seen with the count at its top value
    a_r2_rise_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_active) |-> ($past(tick) && $past(cnt_q) == CNT_MAX));
    // R4: when the pulse ends, the count is empty
    a_r4_clear_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_active) |-> (cnt_q == '0));
    // R5: disabled means idle from the next edge
    a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pulse_active && cnt_q == '0));
    // R3: a service outside a pulse empties the count
    a_r3_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !pulse_active) |=> (cnt_q == '0));
endmodule

// File: rtl/kick_watchdog.sv
// Module: kick_watchdog
// Top of the watchdog: synchronizes the service strobe, divides the slow clock
// into ticks and counts them into a fixed-length reset pulse.
// Assumes one slow clock domain and a strobe that comes from an outside decoder.
module kick_watchdog
    import wdt_pkg::*;
#(
    parameter int          DIV         = 8192,
    parameter int          TICK_W      = 2,
    parameter int          PULSE_CYC   = 4,
    parameter int          SYNC_STAGES = 2,
    parameter clear_mode_e CLEAR_MODE  = PHASE_FREE
) (
    input  logic clk_slow,
    input  logic rst_n,
    input  logic wd_enable,
    input  logic kick_req,
    output logic wd_reset
);
    logic kick_pulse;
    logic tick;
    logic pulse_active;
    logic pre_restart;
    logic phase_clear;

    wdt_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk_slow),
        .rst_n      (rst_n),
        .kick_async (kick_req),
        .kick_pulse (kick_pulse)
    );

    // The mode parameter decides whether a service restarts the prescaler.
    generate
        if (CLEAR_MODE == PHASE_RESTART) begin : g_phase_restart
            assign phase_clear = kick_pulse;
        end else begin : g_phase_free
            assign phase_clear = 1'b0;
        end
    endgenerate

    assign pre_restart = !wd_enable || pulse_active || phase_clear;

    wdt_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .restart (pre_restart),
        .tick    (tick)
    );

    wdt_tick_counter #(.TICK_W(TICK_W), .PULSE_CYC(PULSE_CYC)) u_cnt (
        .clk          (clk_slow),
        .rst_n        (rst_n),
        .enable       (wd_enable),
        .clr          (kick_pulse),
        .tick         (tick),
        .pulse_active (pulse_active)
    );

    assign wd_reset = pulse_active;

    // R6: a reset edge leaves the output low
    a_r6_reset_low: assert property (@(posedge clk_slow)
        !rst_n |=> !wd_reset);
endmodule

// File: tb/kick_watchdog_tb_top.sv
module kick_watchdog_tb_top;
    import wdt_pkg::*;

    localparam int D  = 8;
    localparam int TK = 4;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic kick = 1'b0;
    logic rst0, rst1;
    int   checks = 0;
    int   errors = 0;

    always #4 clk = ~clk;

    kick_watchdog #(.DIV(D), .TICK_W(2), .PULSE_CYC(PL), .CLEAR_MODE(PHASE_FREE)) dut_i (
        .clk_slow (clk), .rst_n (rst_n), .wd_enable (en), .kick_req (kick), .wd_reset (rst0));

    kick_watchdog #(.DIV(D), .TICK_W(2), .PULSE_CYC(PL), .CLEAR_MODE(PHASE_RESTART)) dut_ph_i (
        .clk_slow (clk), .rst_n (rst_n), .wd_enable (en), .kick_req (kick), .wd_reset (rst1));

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs maxn edges from an enable point. Records the first rise and fall of
    // dut_i, its second rise, and the first rise of dut_ph_i (-1 if none).
    task automatic run_window(input int maxn, input int kick_at, input int kick_len,
                              output int r0, output int f0, output int r0b, output int r1);
        logic p0, p1;
        p0 = rst0; p1 = rst1;
        r0 = -1; f0 = -1; r0b = -1; r1 = -1;
        for (int n = 0; n < maxn; n++) begin
            if (kick_at >= 0 && n == kick_at) kick = 1'b1;
            if (kick_at >= 0 && n == kick_at + kick_len) kick = 1'b0;
            step();
            if (rst0 && !p0) begin
                if (r0 < 0) r0 = n + 1;
                else if (r0b < 0) r0b = n + 1;
            end
            if (!rst0 && p0 && f0 < 0) f0 = n + 1;
            if (rst1 && !p1 && r1 < 0) r1 = n + 1;
            p0 = rst0; p1 = rst1;
        end
        kick = 1'b0;
    endtask

    task automatic restart_enable();
        en = 1'b0;
        step();
        step();
        en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0, f0, r0b, r1, c, hi;
        // R6: reset state
        repeat (4) step();
        check("R6 reset dut_i", int'(rst0), 0);
        check("R6 reset dut_ph_i", int'(rst1), 0);
        rst_n = 1'b1;

        // R5: disabled for a long time never fires
        hi = 0;
        for (int n = 0; n < 5 * TK * D; n++) begin
            step();
            if (rst0 || rst1) hi++;
        end
        check("R5 disabled quiet", hi, 0);

        // R2, R4, R1: no service
        en = 1'b1;
        run_window(9 * D, -1, 0, r0, f0, r0b, r1);
        check("R2 first rise", r0, TK * D);
        check("R2 first rise restart mode", r1, TK * D);
        check("R4 pulse length", f0 - r0, PL);
        check("R1 pulse spacing", r0b - r0, TK * D + PL);

        // R3, R7, R8: service sweep over every prescaler phase
        for (int a = 0; a < 2 * D; a++) begin
            restart_enable();
            c = a + 3;  // R7: clear lands on the third edge after the strobe
            run_window(7 * D, a, 3, r0, f0, r0b, r1);
            check("R3 rise after service", r0, (c / D + TK) * D);
            check("R3 window", int'((r0 - c) >= (TK - 1) * D + 1 && (r0 - c) <= TK * D), 1);
            check("R8 restart mode rise", r1, c + TK * D);
        end

        // R7: a strobe held high counts once
        restart_enable();
        run_window(6 * D, 2, 10 * D, r0, f0, r0b, r1);
        check("R7 held strobe dut_i", r0, TK * D);
        check("R7 held strobe dut_ph_i", r1, 5 + TK * D);

        // R5: disabling during a pulse drops the output, enabling restarts
        restart_enable();
        run_window(TK * D + 1, -1, 0, r0, f0, r0b, r1);
        check("R5 pulse before disable", int'(rst0), 1);
        en = 1'b0;
        step();
        check("R5 output low after disable", int'(rst0), 0);
        en = 1'b1;
        run_window(5 * D, -1, 0, r0, f0, r0b, r1);
        check("R5 full restart", r0, TK * D);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule